// File: doc/BRIEF.md
# Buffered UART Transmitter with Output Inversion

This block serialises bytes onto an asynchronous serial line. A byte written through a strobe-and-data port first lands in a one-entry holding buffer. It moves into the shift register as soon as the shifter is free. While the buffer holds a byte that has not been moved yet, a buffer-full flag is raised. Writes that arrive while the flag is up are dropped. A byte placed in the buffer during a frame is sent directly after that frame ends, with a fixed gap of two clocks between the stop bit and the next start bit.

The bit period comes from a 5-bit programmable counter followed by a divide-by-two stage. A divisor setting of D gives a bit period of 2*(D+1) clocks. The divisor is captured only while transmit is disabled. Operation needs the power bit first and a rising transmit-enable after it. Dropping the power bit clears the block. An inversion control flips the serial output level. A one-clock completion pulse marks the end of each frame.

Top module: `bufd_uart_tx`

## Requirements
- R1: With captured divisor D, every bit on the line lasts exactly 2*(D+1) clock cycles. D=0 gives the minimum of 2 clocks.
- R2: An accepted write raises `buf_full` on the next cycle. While `buf_full` is high, further writes are ignored and never appear on the line. `buf_full` falls in the same cycle the buffered byte starts its start bit.
- R3: When a byte waits in the buffer at the end of a frame's stop bit, the line stays at the idle level for exactly 2 extra clocks. After that, the next start bit begins.
- R4: With `inv_out` = 1, `txd` is the complement of the normal line. The idle level is 0 instead of 1.
- R5: The block becomes active only when `tx_en` rises while `pwr_on` is 1. If `tx_en` is already high when `pwr_on` is set, writes are ignored until `tx_en` is cleared and set again. Clearing `pwr_on` returns `txd` to idle and clears `buf_full` and `busy` within two cycles.
- R6: `done_irq` is high for exactly one cycle, the first cycle after a frame's stop bit ends. It is 10 bit periods after the first cycle of the start bit.
- R7: `div_sel` is captured only while `tx_en` is 0. A change made while `tx_en` is 1 has no effect on bit timing.
- R8: A frame consists of one start bit (line 0), the 8 data bits with bit 0 first, and one stop bit (line 1).
- R9: After reset, `txd` is 1 (with `inv_out` = 0), and `buf_full`, `busy` and `done_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power control; 0 stops and clears the block |
| tx_en | input | 1 | Transmit enable; must rise while powered |
| inv_out | input | 1 | 1 inverts the serial output |
| div_sel | input | 5 | Baud divisor D; bit period is 2*(D+1) clocks |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output |
| buf_full | output | 1 | Holding buffer occupied |
| busy | output | 1 | A frame or inter-frame gap is in progress |
| done_irq | output | 1 | One-cycle frame completion pulse |

## Verification
Single frames are sent with bytes whose bit 0 is 1, so the length of the start-bit run shows the bit period directly. They run at divisors 0, 3 and 7, and their data is decoded at bit centres to confirm LSB-first order. A back-to-back pair whose first byte has bit 7 equal to 0 makes the stop-plus-gap run measurable, which separates a two-clock gap from none or from a fresh idle restart. A third write made while the buffer is full must never appear on the line. The enable-order, power-drop, divisor-change-while-enabled and inverted-output cases each compare the line against the plain case, so a wrong gate or latch shows up as a timing or level difference.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_GAP   = 3'd4
  } utx_state_e;

  // Clocks per serial bit for a divisor setting: counter of div+1 then halved.
  function automatic int unsigned bit_clocks(input int unsigned div);
    return 2 * (div + 1);
  endfunction

endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] div_sel,
  output logic             active,
  output logic [DIV_W-1:0] div_q
);

  logic en_d;

  // Active only after a tx_en rise seen with power on; power loss clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b0;
      active <= 1'b0;
      div_q  <= '0;
    end else begin
      en_d   <= tx_en;
      active <= pwr_on & tx_en & (active | ~en_d);
      if (!tx_en) div_q <= div_sel;
    end
  end

  assert_power_off_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !active);

  assert_div_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> $stable(div_q));

endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam int SC_W = DIV_W + 2;

  logic [DIV_W-1:0] cnt;
  logic             half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (cnt == div) begin
      cnt  <= '0;
      half <= ~half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run & half & (cnt == div);

  // Independent cycle count between ticks for the period check.
  logic [SC_W-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since <= '0;
    else if (!run || tick)  since <= '0;
    else                    since <= since + 1'b1;
  end

  assert_bit_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (since == SC_W'(utx_pkg::bit_clocks(int'(div)) - 1)));

endmodule

// File: rtl/utx_core.sv
module utx_core #(
  parameter int DATA_W   = 8,
  parameter int GAP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              inv_out,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              run,
  output logic              txd,
  output logic              buf_full,
  output logic              busy,
  output logic              done_irq
);
  import utx_pkg::*;

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int GAP_W = $clog2(GAP_CLKS + 1);

  utx_state_e        state;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] sh;
  logic [BIT_W-1:0]  bitn;
  logic [GAP_W-1:0]  gapc;
  logic              line;

  // Named internal events
  logic wr_ok, load, frame_end;
  assign wr_ok     = active & wr_stb & ~buf_full;
  assign frame_end = (state == ST_STOP) & tick;
  assign load      = active & buf_full &
                     ((state == ST_IDLE) ||
                      ((state == ST_GAP) && (gapc == GAP_W'(GAP_CLKS - 1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; buf_q <= '0; buf_full <= 1'b0;
      sh <= '0; bitn <= '0; gapc <= '0; done_irq <= 1'b0;
    end else if (!active) begin
      state <= ST_IDLE; buf_full <= 1'b0;
      bitn <= '0; gapc <= '0; done_irq <= 1'b0;
    end else begin
      done_irq <= frame_end;
      if (wr_ok) begin
        buf_q    <= wr_data;
        buf_full <= 1'b1;
      end else if (load) begin
        buf_full <= 1'b0;
      end
      case (state)
        ST_IDLE: if (load) begin sh <= buf_q; state <= ST_START; end
        ST_START: if (tick) begin bitn <= '0; state <= ST_DATA; end
        ST_DATA: if (tick) begin
          sh <= sh >> 1;
          if (bitn == BIT_W'(DATA_W - 1)) state <= ST_STOP;
          else bitn <= bitn + 1'b1;
        end
        ST_STOP: if (tick) begin
          gapc  <= '0;
          state <= buf_full ? ST_GAP : ST_IDLE;
        end
        ST_GAP: begin
          if (load) begin sh <= buf_q; state <= ST_START; end
          else gapc <= gapc + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      default:  line = 1'b1;
    endcase
  end

  assign run  = (state == ST_START) || (state == ST_DATA) || (state == ST_STOP);
  assign txd  = line ^ inv_out;
  assign busy = (state != ST_IDLE);

  // Gap-length watcher for the back-to-back check
  logic [GAP_W:0] gap_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_run <= '0;
    else if (state == ST_GAP)  gap_run <= gap_run + 1'b1;
    else                       gap_run <= '0;
  end

  assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n || !active)
    (buf_full && !load) |=> (buf_full && $stable(buf_q)));

  assert_gap_two_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_START) && ($past(state) == ST_GAP)) |-> (gap_run == (GAP_W+1)'(GAP_CLKS)));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (txd == ~inv_out));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

endmodule

// File: rtl/bufd_uart_tx.sv
module bufd_uart_tx #(
  parameter int DIV_W    = 5,
  parameter int DATA_W   = 8,
  parameter int GAP_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              tx_en,
  input  logic              inv_out,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_full,
  output logic              busy,
  output logic              done_irq
);

  logic             active;
  logic [DIV_W-1:0] div_q;
  logic             run;
  logic             tick;

  utx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_en(tx_en),
    .div_sel(div_sel), .active(active), .div_q(div_q)
  );

  utx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  utx_core #(.DATA_W(DATA_W), .GAP_CLKS(GAP_CLKS)) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .inv_out(inv_out),
    .wr_stb(wr_stb), .wr_data(wr_data), .tick(tick), .run(run),
    .txd(txd), .buf_full(buf_full), .busy(busy), .done_irq(done_irq)
  );

endmodule

// File: tb/tb_bufd_uart_tx.sv
module tb_bufd_uart_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on = 1'b0, tx_en = 1'b0, inv_out = 1'b0, wr_stb = 1'b0;
  logic [4:0] div_sel = '0;
  logic [7:0] wr_data = '0;
  logic       txd, buf_full, busy, done_irq;

  int checks = 0;
  int errors = 0;

  logic smp_line [0:511];
  logic smp_irq  [0:511];

  always #2 clk = ~clk;

  bufd_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_en(tx_en), .inv_out(inv_out),
    .div_sel(div_sel), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .buf_full(buf_full), .busy(busy), .done_irq(done_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic enable(input int d);
    @(negedge clk); tx_en = 1'b0; div_sel = 5'(d); pwr_on = 1'b1;
    @(negedge clk);
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic record(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_line[i] = txd ^ inv_out;
      smp_irq[i]  = done_irq;
    end
  endtask

  function automatic int first_low(input int from, input int n);
    for (int i = from; i < n; i++) if (smp_line[i] == 1'b0) return i;
    return -1;
  endfunction

  // Checks one recorded frame; expected byte must have bit 0 = 1.
  task automatic check_frame(input int from, input int n, input int p,
                             input logic [7:0] exp, output int s);
    int run_len, irqs;
    logic [7:0] got;
    s = first_low(from, n);
    chk(s >= 0, "R8 start bit found", s, from);
    if (s < 0) return;
    run_len = 0;
    while (s + run_len < n && smp_line[s + run_len] == 1'b0) run_len++;
    chk(run_len == p, "R1 start bit length", run_len, p);
    for (int b = 0; b < 8; b++) got[b] = smp_line[s + (b + 1) * p + p / 2];
    chk(got == exp, "R8 data LSB first", int'(got), int'(exp));
    chk(smp_line[s + 9 * p + p / 2] == 1'b1, "R8 stop bit", int'(smp_line[s + 9 * p + p / 2]), 1);
    irqs = 0;
    for (int i = s; i < s + 10 * p + 4 && i < n; i++) irqs += int'(smp_irq[i]);
    chk(irqs == 1 && smp_irq[s + 10 * p] == 1'b1, "R6 done pulse", irqs, 1);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R9 txd idle", int'(txd), 1);
    chk(buf_full == 1'b0, "R9 buf_full", int'(buf_full), 0);
    chk(busy == 1'b0, "R9 busy", int'(busy), 0);
    chk(done_irq == 1'b0, "R9 done_irq", int'(done_irq), 0);
  endtask

  task automatic t_single(input int d, input logic [7:0] b);
    int s;
    enable(d);
    fork
      record(10 * (2 * (d + 1)) + 20);
      wr(b);
    join
    check_frame(0, 10 * (2 * (d + 1)) + 20, 2 * (d + 1), b, s);
  endtask

  task automatic t_order();
    @(negedge clk); tx_en = 1'b0; pwr_on = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk); pwr_on = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h81);
    repeat (3) @(negedge clk);
    chk(buf_full == 1'b0 && busy == 1'b0, "R5 enable before power ignored", int'(buf_full), 0);
    chk(txd == 1'b1, "R5 line idle while not armed", int'(txd), 1);
  endtask

  task automatic t_back2back();
    int s1, s2, n, extra;
    n = 300;
    enable(3);
    fork
      record(n);
      begin
        wr(8'h35);
        while (buf_full) @(negedge clk);
        wr(8'h4B);
        chk(buf_full == 1'b1, "R2 flag after write", int'(buf_full), 1);
        repeat (5) @(negedge clk);
        wr(8'hFF);
      end
    join
    check_frame(0, n, 8, 8'h35, s1);
    check_frame(s1 + 9 * 8 + 5, n, 8, 8'h4B, s2);
    chk(s2 == s1 + 80 + 2, "R3 two-clock gap", s2 - s1, 82);
    extra = first_low(s2 + 80, n);
    chk(extra == -1, "R2 write while full dropped", extra, -1);
  endtask

  task automatic t_div_lock();
    int s;
    enable(3);
    @(negedge clk); div_sel = 5'd7;
    fork record(100); wr(8'hC3); join
    check_frame(0, 100, 8, 8'hC3, s);
    enable(7);
    fork record(180); wr(8'hC3); join
    check_frame(0, 180, 16, 8'hC3, s);
  endtask

  task automatic t_invert();
    int s;
    @(negedge clk); inv_out = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R4 inverted idle level", int'(txd), 0);
    enable(1);
    fork record(60); wr(8'h6D); join
    check_frame(0, 60, 4, 8'h6D, s);
    @(negedge clk); inv_out = 1'b0;
  endtask

  task automatic t_power_drop();
    enable(3);
    wr(8'h11);
    repeat (20) @(negedge clk);
    wr(8'h22);
    chk(buf_full == 1'b1 && busy == 1'b1, "R5 busy before power drop", int'(buf_full), 1);
    @(negedge clk); pwr_on = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(txd == 1'b1 && buf_full == 1'b0 && busy == 1'b0, "R5 power drop clears",
        int'({txd, buf_full, busy}), 4);
    @(negedge clk); pwr_on = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h33);
    repeat (2) @(negedge clk);
    chk(buf_full == 1'b0 && busy == 1'b0, "R5 re-power needs new enable", int'(buf_full), 0);
    enable(3);
    wr(8'h33);
    chk(buf_full == 1'b1 || busy == 1'b1, "R5 re-armed accepts write", int'(busy), 1);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_order();
    t_single(0, 8'hA5);
    t_single(3, 8'h35);
    t_back2back();
    t_div_lock();
    t_invert();
    t_power_drop();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule